// File: doc/BRIEF.md
# Token-Passing Readout Sequencer

This block empties the conversion count registers of one channel onto a shared 12-bit data bus. Several chips share that bus in a daisy chain. Each chip owns a small run of channel addresses, and a single token travels along the chain. When the token reaches a chip and the 5-bit address on the shared select lines falls inside that chip's run, the chip reads out all 256 words of the addressed channel. It places one word on the bus per read-clock cycle, with a data-valid strobe beside each word. When the last word has gone out, it hands the token to the next chip.

If the address belongs to another chip, the token passes straight through after one cycle and this chip never drives the bus. A chip that is not driving leaves the bus at logic zero. This models the weak pull-down of the bus pads.

The count storage itself is outside the block. The sequencer presents a channel index and a word index, and the storage answers with the addressed word in the same cycle. An asynchronous token clear aborts any readout at once. At the nominal 40 MHz read clock each word takes 25 ns, so a four-channel readout takes 4 x 256 read cycles.

Top module: `tokrd_seq`

## Requirements
- R1: After reset, `bus_data` is 0, and `bus_oe`, `dvalid` and `tok_out` are 0.
- R2: If `tok_in` is high at a rising `rd_clk` edge while the block is idle and `chan_addr` lies in BASE_ADDR..BASE_ADDR+N_CHAN-1, readout starts at that edge. Word 0 is on the bus after that edge.
- R3: During readout, `bus_oe` and `dvalid` are high for exactly N_WORDS (256) consecutive cycles. In the j-th cycle, `mem_idx` = j and `bus_data` equals `mem_word`, the storage word for (`mem_chan`, j).
- R4: `tok_out` is high for exactly one cycle, in the cycle right after the last word, and `bus_oe` is 0 in that cycle.
- R5: The address compare decides two things. For an address inside the chip's run, `mem_chan` = `chan_addr` - BASE_ADDR. For any other address, `tok_out` pulses for one cycle, in the cycle after the token edge, and `bus_oe` stays 0.
- R6: Once readout has started, changes on `tok_in` and `chan_addr` have no effect. The same channel is read to the end and the word count stays 256.
- R7: `tok_clr` high acts asynchronously. It forces `bus_oe`, `dvalid` and `tok_out` to 0 and `bus_data` to 0, and it returns the word counter to 0, so the next readout starts at word 0.
- R8: Whenever `bus_oe` is 0, `bus_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_clr | input | 1 | Asynchronous token clear, active high |
| tok_in | input | 1 | Token from the previous chip |
| chan_addr | input | 5 | Channel address select |
| tok_out | output | 1 | Token to the next chip, one-cycle pulse |
| mem_chan | output | 2 | Local channel index presented to storage |
| mem_idx | output | 8 | Word index presented to storage |
| mem_word | input | 12 | Word returned by storage |
| bus_data | output | 12 | Shared data bus, 0 when not driven |
| bus_oe | output | 1 | Bus drive enable |
| dvalid | output | 1 | Data-valid strobe per word |

## Verification
The hardest situation to reach from the ports is a token clear that lands partway through a readout. To be useful, that clear must be followed by a fresh readout, so the bench can see whether the word counter really returned to zero or kept counting from where it stopped. The bench starts a readout, lets ten words pass and raises the clear between clock edges. It checks the outputs one time step later to confirm the release is asynchronous, then holds the clear across an edge. Next it passes a new token and checks that the first words come back from index 0. A second clear, raised during the token-out pulse, shows that the pulse is dropped. Around this, the bench sweeps all 32 addresses: full readouts for the four in range, with one of them disturbed by token and address changes in mid-run, and pass-through for the other 28.

// File: rtl/tokrd_pkg.sv
package tokrd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_PASS = 2'd2
   } tok_state_e;
endpackage

// File: rtl/tokrd_match.sv
module tokrd_match #(
   parameter int ADDR_W    = 5,
   parameter int N_CHAN    = 4,
   parameter int BASE_ADDR = 0,
   localparam int CH_W     = (N_CHAN > 1) ? $clog2(N_CHAN) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [CH_W-1:0]   sel
);
   localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(BASE_ADDR);
   localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(BASE_ADDR + N_CHAN);

   logic [ADDR_W-1:0] offs;
   assign offs = addr - ADDR_W'(BASE_ADDR);

   generate
      if (N_CHAN == 1) begin : g_single
         assign hit = (addr == ADDR_W'(BASE_ADDR));
         assign sel = '0;
      end else begin : g_range
         logic [ADDR_W:0] ax;
         assign ax  = {1'b0, addr};
         assign hit = (ax >= LO) && (ax < HI);
         assign sel = offs[CH_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/tokrd_idx.sv
module tokrd_idx #(
   parameter int N_WORDS = 256,
   localparam int IDX_W  = $clog2(N_WORDS)
) (
   input  logic             clk,
   input  logic             arst,
   input  logic             step,
   output logic [IDX_W-1:0] idx,
   output logic             at_last
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(N_WORDS - 1);

   assign at_last = (idx == LAST);

   always_ff @(posedge clk or posedge arst) begin
      if (arst)
         idx <= '0;
      else if (step)
         idx <= at_last ? '0 : idx + 1'b1;
   end
endmodule

// File: rtl/tokrd_fsm.sv
module tokrd_fsm
   import tokrd_pkg::*;
#(
   parameter int CH_W = 2
) (
   input  logic            clk,
   input  logic            arst,
   input  logic            tok_in,
   input  logic            hit,
   input  logic [CH_W-1:0] sel,
   input  logic            at_last,
   output logic            run,
   output logic            pass,
   output logic [CH_W-1:0] chan_q
);
   tok_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (tok_in) st_d = hit ? ST_RUN : ST_PASS;
         ST_RUN:  if (at_last) st_d = ST_PASS;
         ST_PASS: st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         st_q   <= ST_IDLE;
         chan_q <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_IDLE && tok_in && hit)
            chan_q <= sel;
      end
   end

   assign run  = (st_q == ST_RUN);
   assign pass = (st_q == ST_PASS);
endmodule

// File: rtl/tokrd_seq.sv
module tokrd_seq #(
   parameter int WORD_W    = 12,
   parameter int N_WORDS   = 256,
   parameter int ADDR_W    = 5,
   parameter int N_CHAN    = 4,
   parameter int BASE_ADDR = 0,
   localparam int IDX_W    = $clog2(N_WORDS),
   localparam int CH_W     = (N_CHAN > 1) ? $clog2(N_CHAN) : 1
) (
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              tok_clr,
   input  logic              tok_in,
   input  logic [ADDR_W-1:0] chan_addr,
   output logic              tok_out,
   output logic [CH_W-1:0]   mem_chan,
   output logic [IDX_W-1:0]  mem_idx,
   input  logic [WORD_W-1:0] mem_word,
   output logic [WORD_W-1:0] bus_data,
   output logic              bus_oe,
   output logic              dvalid
);
   generate
      if (WORD_W < 1) begin : g_bad_width
         $error("tokrd_seq: WORD_W must be at least 1");
      end
      if (N_WORDS < 2) begin : g_bad_depth
         $error("tokrd_seq: N_WORDS must be at least 2");
      end
      if (N_CHAN < 1 || BASE_ADDR < 0 || BASE_ADDR + N_CHAN > (1 << ADDR_W)) begin : g_bad_range
         $error("tokrd_seq: channel run exceeds address space");
      end
   endgenerate

   logic arst, hit, run, pass, at_last;
   logic [CH_W-1:0] sel;

   assign arst = ~rst_n | tok_clr;

   tokrd_match #(
      .ADDR_W(ADDR_W), .N_CHAN(N_CHAN), .BASE_ADDR(BASE_ADDR)
   ) u_match (
      .addr(chan_addr), .hit(hit), .sel(sel)
   );

   tokrd_fsm #(.CH_W(CH_W)) u_fsm (
      .clk(rd_clk), .arst(arst), .tok_in(tok_in), .hit(hit), .sel(sel),
      .at_last(at_last), .run(run), .pass(pass), .chan_q(mem_chan)
   );

   tokrd_idx #(.N_WORDS(N_WORDS)) u_idx (
      .clk(rd_clk), .arst(arst), .step(run), .idx(mem_idx), .at_last(at_last)
   );

   assign tok_out  = pass;
   assign bus_oe   = run;
   assign dvalid   = run;
   assign bus_data = run ? mem_word : '0;
endmodule

// File: rtl/tokrd_seq_chk.sv
module tokrd_seq_chk #(
   parameter int WORD_W = 12,
   parameter int IDX_W  = 8,
   parameter int CH_W   = 2
) (
   input logic              rd_clk,
   input logic              rst_n,
   input logic              tok_clr,
   input logic              tok_out,
   input logic              bus_oe,
   input logic              dvalid,
   input logic [WORD_W-1:0] bus_data,
   input logic [IDX_W-1:0]  mem_idx,
   input logic [CH_W-1:0]   mem_chan
);
   a_r8_idle_zero: assert property (@(posedge rd_clk) disable iff (!rst_n || tok_clr)
      !bus_oe |-> bus_data == '0);
   a_r4_tok_pulse: assert property (@(posedge rd_clk) disable iff (!rst_n || tok_clr)
      tok_out |=> !tok_out);
   a_r4_tok_after_run: assert property (@(posedge rd_clk) disable iff (!rst_n || tok_clr)
      $fell(bus_oe) |-> tok_out);
   a_r4_no_overlap: assert property (@(posedge rd_clk) disable iff (!rst_n || tok_clr)
      tok_out |-> !bus_oe);
   a_r2_start_idx0: assert property (@(posedge rd_clk) disable iff (!rst_n || tok_clr)
      $rose(bus_oe) |-> mem_idx == '0);
   a_r3_idx_step: assert property (@(posedge rd_clk) disable iff (!rst_n || tok_clr)
      (bus_oe && $past(bus_oe)) |-> mem_idx == $past(mem_idx) + 1'b1);
   a_r6_chan_hold: assert property (@(posedge rd_clk) disable iff (!rst_n || tok_clr)
      (bus_oe && $past(bus_oe)) |-> $stable(mem_chan));
   a_r3_strobe: assert property (@(posedge rd_clk) disable iff (!rst_n || tok_clr)
      bus_oe == dvalid);
endmodule

bind tokrd_seq tokrd_seq_chk #(
   .WORD_W(WORD_W), .IDX_W(IDX_W), .CH_W(CH_W)
) u_chk (
   .rd_clk(rd_clk), .rst_n(rst_n), .tok_clr(tok_clr), .tok_out(tok_out),
   .bus_oe(bus_oe), .dvalid(dvalid), .bus_data(bus_data),
   .mem_idx(mem_idx), .mem_chan(mem_chan)
);

// File: tb/tokrd_seq_tb.sv
module tokrd_seq_tb_top;
   localparam int WW = 12, NW = 256, AW = 5, NC = 4, BASE = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0, tok_clr = 1'b0, tok_in = 1'b0;
   logic [AW-1:0] chan_addr = '0;
   logic tok_out, bus_oe, dvalid;
   logic [1:0] mem_chan;
   logic [7:0] mem_idx;
   logic [WW-1:0] mem_word, bus_data;
   int total = 0, bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   function automatic logic [WW-1:0] stor(input int ch, input int i);
      return WW'(((ch * 37 + i * 13) ^ (i << 4)) & 12'hFFF);
   endfunction

   assign mem_word = stor(int'(mem_chan), int'(mem_idx));

   tokrd_seq #(.WORD_W(WW), .N_WORDS(NW), .ADDR_W(AW), .N_CHAN(NC), .BASE_ADDR(BASE)) dut_i (
      .rd_clk(clk), .rst_n(rst_n), .tok_clr(tok_clr), .tok_in(tok_in),
      .chan_addr(chan_addr), .tok_out(tok_out), .mem_chan(mem_chan),
      .mem_idx(mem_idx), .mem_word(mem_word), .bus_data(bus_data),
      .bus_oe(bus_oe), .dvalid(dvalid)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic give_token(input int addr);
      @(negedge clk);
      chan_addr = AW'(addr);
      tok_in = 1'b1;
      @(negedge clk);
      tok_in = 1'b0;
   endtask

   // full readout starting right after give_token; disturb exercises R6
   task automatic read_all(input int ch, input bit disturb);
      for (int j = 0; j < NW; j++) begin
         chk("R3 oe", int'(bus_oe), 1);
         chk("R3 dvalid", int'(dvalid), 1);
         chk("R3 idx", int'(mem_idx), j);
         chk("R5 chan", int'(mem_chan), ch);
         chk("R3 word", int'(bus_data), int'(stor(ch, j)));
         chk("R4 no early token", int'(tok_out), 0);
         if (disturb && (j == 5 || j == 100)) begin
            tok_in = 1'b1;
            chan_addr = AW'(j);
         end else if (disturb) begin
            tok_in = 1'b0;
         end
         @(negedge clk);
      end
      tok_in = 1'b0;
      chk("R4 token out", int'(tok_out), 1);
      chk("R4 oe low", int'(bus_oe), 0);
      chk("R8 bus zero", int'(bus_data), 0);
      @(negedge clk);
      chk("R4 token one cycle", int'(tok_out), 0);
      chk("R6 no restart", int'(bus_oe), 0);
   endtask

   initial begin
      #5;
      chk("R1 bus", int'(bus_data), 0);
      chk("R1 oe", int'(bus_oe), 0);
      chk("R1 dvalid", int'(dvalid), 0);
      chk("R1 tok_out", int'(tok_out), 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset", int'(bus_oe) + int'(tok_out), 0);

      // R2 R5 address sweep over all 32 addresses
      for (int a = 0; a < 32; a++) begin
         give_token(a);
         if (a >= BASE && a < BASE + NC) begin
            read_all(a - BASE, a == BASE + 2);
         end else begin
            chk("R5 bypass token", int'(tok_out), 1);
            chk("R5 bypass no drive", int'(bus_oe), 0);
            chk("R8 bypass bus", int'(bus_data), 0);
            @(negedge clk);
            chk("R5 bypass pulse end", int'(tok_out), 0);
            chk("R5 bypass still idle", int'(bus_oe), 0);
         end
      end

      // R7 clear mid-readout, asynchronous release, counter back to 0
      give_token(BASE + 1);
      repeat (10) @(negedge clk);
      chk("R7 running idx", int'(mem_idx), 10);
      #3 tok_clr = 1'b1;
      #1;
      chk("R7 oe async", int'(bus_oe), 0);
      chk("R7 dvalid async", int'(dvalid), 0);
      chk("R7 bus async", int'(bus_data), 0);
      @(negedge clk);
      tok_clr = 1'b0;
      @(negedge clk);
      chk("R7 stays idle", int'(bus_oe), 0);
      give_token(BASE + 3);
      for (int j = 0; j < 3; j++) begin
         chk("R7 restart idx", int'(mem_idx), j);
         chk("R7 restart word", int'(bus_data), int'(stor(3, j)));
         @(negedge clk);
      end
      tok_clr = 1'b1;
      @(negedge clk);
      tok_clr = 1'b0;

      // R7 clear drops token pulse
      give_token(0);
      chk("R7 pulse present", int'(tok_out), 1);
      #3 tok_clr = 1'b1;
      #1;
      chk("R7 tok_out async", int'(tok_out), 0);
      @(negedge clk);
      tok_clr = 1'b0;
      @(negedge clk);

      // one more clean readout after clears
      give_token(BASE);
      read_all(0, 1'b0);

      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule